// File: doc/BRIEF.md
# Dual-Source Supply Switch Controller

This controller decides whether the downstream logic runs from a battery or from the supply recovered from a coil field. It sees only digital inputs. One comparator bit says the coil voltage is above the field-on threshold. A second says the coil voltage is below the field-off threshold. A timing tick sets the pace of every delay.

The controller does not switch on a single sample. In each direction, the comparator condition must hold for a programmable number of consecutive ticks. The move to field supply needs no battery-status input, so it also works with the battery flat. Each change of supply is reported to the host:

- Entering field supply produces a one-cycle wake strobe.
- Falling back to battery drives an active-low reset line for a programmable number of ticks.

A serial command decoder can turn automatic switching off and on through mode bytes. The resulting flag is cleared only by a power-on reset. The shared reset line works in both directions. A low level driven by someone else returns the controller to battery. The controller's own reset pulse on that line is not treated as an external reset.

Top module: `supply_switch_ctrl`

## Requirements
- R1: After power-on reset (`por_n` low), `supply_field`, `rst_line_oe` and `field_wake` are 0, and automatic mode is enabled, so a qualified field then switches to field supply.
- R2: On battery with automatic mode enabled, the block moves to field supply on the clock edge of the BF_TICKS-th consecutive tick on which `coil_above_on` is 1.
- R3: If the qualifying input (`coil_above_on` on battery, `coil_below_off` on field) drops before the count completes, the count restarts from zero.
- R4: On field supply, the block returns to battery on the clock edge of the FB_TICKS-th consecutive tick on which `coil_below_off` is 1.
- R5: Every return from field to battery caused by R4 or R9 sets `rst_line_oe` (drive the reset line low) in the same cycle that `supply_field` falls. It stays set for RST_TICKS ticks.
- R6: The delay counters and the reset pulse counter advance only on cycles where `tick` is 1.
- R7: `field_wake` is 1 for exactly the one cycle in which `supply_field` has just risen, and at no other time.
- R8: A byte with `cmd_valid`=1, bits [7:6]=11 and bits [2:0]=111 sets automatic mode to the value of bit 3 (1 = enable, 0 = disable). Any other byte, or any byte with `cmd_valid`=0, changes nothing.
- R9: While automatic mode is disabled, the block stays on battery. A disable received while on field supply forces the return to battery two cycles after the command cycle, with the R5 pulse.
- R10: A low level on `rst_line_in` while `rst_line_oe` is 0 has these effects on the next edge: the block goes to battery, the qualification count clears, no reset pulse is issued, and the automatic-mode flag is kept. The block's own pulse on the line never resets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| tick | input | 1 | Timing strobe; delays count these |
| coil_above_on | input | 1 | Coil voltage above the field-on threshold |
| coil_below_off | input | 1 | Coil voltage below the field-off threshold |
| cmd_valid | input | 1 | Qualifies `cmd_byte` for one cycle |
| cmd_byte | input | 8 | Control byte from the serial command decoder |
| rst_line_in | input | 1 | Sensed level of the shared active-low reset line |
| rst_line_oe | output | 1 | 1 = pull the reset line low |
| supply_field | output | 1 | 1 = field supply selected, 0 = battery |
| field_wake | output | 1 | One-cycle strobe on entry into field supply |

## Verification
The bound checker watches the following on every cycle:
- `field_wake` stays tied to a rising edge of the supply selection.
- Every fallback that was not caused by an external reset comes with the reset drive.
- No switch to field happens before BF_TICKS consecutive qualifying ticks have been seen.
- With automatic mode off, the supply stays on battery.
- An external low on the reset line always forces battery.

Some properties depend on exact cycle positions and command sequences, so only the bench scenarios can show them:
- exact switch cycles in both directions;
- the restart after an interrupted interval;
- frozen counting while `tick` is low;
- the precise pulse width;
- the ignored command bytes;
- the flag surviving an external reset but not a power-on reset.

// File: rtl/supply_switch_ctrl.sv
module supply_switch_ctrl #(
  parameter int BF_TICKS  = 1000,
  parameter int FB_TICKS  = 10000,
  parameter int RST_TICKS = 16
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       tick,
  input  logic       coil_above_on,
  input  logic       coil_below_off,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  input  logic       rst_line_in,
  output logic       rst_line_oe,
  output logic       supply_field,
  output logic       field_wake
);
  localparam int MAXD = (BF_TICKS > FB_TICKS) ? BF_TICKS : FB_TICKS;
  localparam int CW   = $clog2(MAXD + 1);
  localparam int RW   = $clog2(RST_TICKS + 1);
  localparam logic [CW-1:0] BF_LAST = CW'(BF_TICKS - 1);
  localparam logic [CW-1:0] FB_LAST = CW'(FB_TICKS - 1);
  localparam logic [RW-1:0] RST_LOAD = RW'(RST_TICKS);

  logic [CW-1:0] qual_q;
  logic [RW-1:0] rpulse_q;
  logic          auto_en_q;

  logic mode_cmd, ext_rst, qual_in, force_batt, at_last, fall;

  assign mode_cmd   = cmd_valid && (cmd_byte[7:6] == 2'b11) && (cmd_byte[2:0] == 3'b111);
  assign rst_line_oe = (rpulse_q != '0);
  assign ext_rst    = !rst_line_in && !rst_line_oe;
  assign qual_in    = supply_field ? coil_below_off : (coil_above_on && auto_en_q);
  assign force_batt = supply_field && !auto_en_q;
  assign at_last    = (qual_q == (supply_field ? FB_LAST : BF_LAST));
  assign fall       = supply_field && !ext_rst &&
                      (force_batt || (qual_in && tick && at_last));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        auto_en_q <= 1'b1;
    else if (mode_cmd) auto_en_q <= cmd_byte[3];
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      supply_field <= 1'b0;
      qual_q       <= '0;
      field_wake   <= 1'b0;
    end else begin
      field_wake <= 1'b0;
      if (ext_rst || force_batt) begin
        supply_field <= 1'b0;
        qual_q       <= '0;
      end else if (!qual_in) begin
        qual_q <= '0;
      end else if (tick) begin
        if (at_last) begin
          supply_field <= !supply_field;
          field_wake   <= !supply_field;
          qual_q       <= '0;
        end else begin
          qual_q <= qual_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                       rpulse_q <= '0;
    else if (fall)                    rpulse_q <= RST_LOAD;
    else if (tick && rst_line_oe)     rpulse_q <= rpulse_q - 1'b1;
  end
endmodule

// File: rtl/supply_switch_ctrl_chk.sv
module supply_switch_ctrl_chk #(
  parameter int BF_TICKS = 1000
) (
  input logic clk,
  input logic por_n,
  input logic tick,
  input logic coil_above_on,
  input logic rst_line_in,
  input logic rst_line_oe,
  input logic supply_field,
  input logic field_wake,
  input logic auto_en_q
);
  localparam int SW = $clog2(BF_TICKS + 1);
  logic [SW-1:0] seen_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                                     seen_q <= '0;
    else if (!coil_above_on)                        seen_q <= '0;
    else if (tick && (seen_q < SW'(BF_TICKS)))      seen_q <= seen_q + 1'b1;
  end

  a_r2_enough_ticks: assert property (@(posedge clk) disable iff (!por_n)
    $rose(supply_field) |-> (seen_q >= SW'(BF_TICKS)));

  a_r5_fallback_drives_reset: assert property (@(posedge clk) disable iff (!por_n)
    ($fell(supply_field) && $past(rst_line_in || rst_line_oe)) |-> rst_line_oe);

  a_r7_wake_only_on_entry: assert property (@(posedge clk) disable iff (!por_n)
    field_wake |-> $rose(supply_field));

  a_r7_entry_gives_wake: assert property (@(posedge clk) disable iff (!por_n)
    $rose(supply_field) |-> field_wake);

  a_r9_disabled_stays_battery: assert property (@(posedge clk) disable iff (!por_n)
    !auto_en_q |=> !supply_field);

  a_r10_external_reset: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_line_in && !rst_line_oe) |=> (!supply_field && !field_wake));
endmodule

bind supply_switch_ctrl supply_switch_ctrl_chk #(.BF_TICKS(BF_TICKS)) u_chk (
  .clk(clk), .por_n(por_n), .tick(tick), .coil_above_on(coil_above_on),
  .rst_line_in(rst_line_in), .rst_line_oe(rst_line_oe),
  .supply_field(supply_field), .field_wake(field_wake), .auto_en_q(auto_en_q)
);

// File: tb/supply_switch_ctrl_bench.sv
`timescale 1ns/1ps
module supply_switch_ctrl_bench;
  localparam int BF  = 8;
  localparam int FB  = 12;
  localparam int RST = 5;

  typedef struct {
    int    at;
    bit    sup;
    bit    oe;
    bit    wk;
    string tag;
  } exp_t;

  logic clk = 1'b0, por_n = 1'b0, tick = 1'b0;
  logic above = 1'b0, below = 1'b0, cmd_valid = 1'b0, ext_pull = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic rst_line_in, rst_line_oe, supply_field, field_wake;

  assign rst_line_in = !(rst_line_oe || ext_pull);

  supply_switch_ctrl #(.BF_TICKS(BF), .FB_TICKS(FB), .RST_TICKS(RST)) u_supply_switch_ctrl (
    .clk(clk), .por_n(por_n), .tick(tick), .coil_above_on(above), .coil_below_off(below),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .rst_line_in(rst_line_in),
    .rst_line_oe(rst_line_oe), .supply_field(supply_field), .field_wake(field_wake)
  );

  always #5 clk = ~clk;

  int   cyc = 0, checks = 0, fails = 0;
  bit   done = 1'b0;
  exp_t sb[$];
  exp_t it;

  always @(posedge clk) begin
    #2;
    cyc++;
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      it = sb.pop_front();
      checks++;
      if (it.at != cyc || supply_field !== it.sup || rst_line_oe !== it.oe || field_wake !== it.wk) begin
        fails++;
        $display("FAIL %s cycle %0d: got sup=%b oe=%b wake=%b expected sup=%b oe=%b wake=%b",
                 it.tag, it.at, supply_field, rst_line_oe, field_wake, it.sup, it.oe, it.wk);
      end
    end
  end

  task automatic push(input int at, input bit s, input bit o, input bit w, input string tag);
    exp_t e;
    e.at = at; e.sup = s; e.oe = o; e.wk = w; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic pulse_cmd(input logic [7:0] b, input bit v);
    cmd_byte = b; cmd_valid = v;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic pulse_ext();
    ext_pull = 1'b1;
    @(negedge clk);
    ext_pull = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired (all requirements): got running expected finished");
      finish_run();
    end
  end

  initial begin
    int c, r, p;
    repeat (3) @(negedge clk);
    c = cyc;
    push(c + 1, 0, 0, 0, "R1 reset state");
    por_n = 1'b1; tick = 1'b1;
    wait_cyc(c + 3);

    // R2 / R7: qualified entry into field supply
    @(negedge clk); c = cyc;
    push(c + BF - 1, 0, 0, 0, "R2 not before BF ticks");
    push(c + BF,     1, 0, 1, "R2/R7 switch with wake");
    push(c + BF + 1, 1, 0, 0, "R7 wake one cycle");
    above = 1'b1;
    wait_cyc(c + BF + 2);

    // R4 / R5 fallback; R10 own pulse does not reset
    @(negedge clk); c = cyc;
    push(c + FB - 1,       1, 0, 0, "R4 not before FB ticks");
    push(c + FB,           0, 1, 0, "R4/R5 fallback with reset");
    push(c + FB + RST - 1, 0, 1, 0, "R5 pulse still active");
    push(c + FB + RST,     0, 0, 0, "R5 pulse ended");
    push(c + FB + BF,      1, 0, 1, "R10 own pulse ignored");
    above = 1'b0; below = 1'b1;
    wait_cyc(c + FB);
    below = 1'b0; above = 1'b1;
    wait_cyc(c + FB + BF + 1);

    // R3 interrupted fallback interval
    @(negedge clk); c = cyc; r = c + FB - 1;
    push(c + FB,     1, 0, 0, "R3 no fallback after blip");
    push(r + FB - 1, 1, 0, 0, "R3 restart still counting");
    push(r + FB,     0, 1, 0, "R3 fallback after restart");
    above = 1'b0; below = 1'b1;
    wait_cyc(c + FB - 2); below = 1'b0;
    wait_cyc(c + FB - 1); below = 1'b1;
    wait_cyc(r + FB); below = 1'b0;
    wait_cyc(r + FB + RST + 1);

    // R3 interrupted entry interval
    @(negedge clk); c = cyc; r = c + BF - 1;
    push(c + BF,     0, 0, 0, "R3 no entry after blip");
    push(r + BF - 1, 0, 0, 0, "R3 restart still counting");
    push(r + BF,     1, 0, 1, "R3 entry after restart");
    above = 1'b1;
    wait_cyc(c + BF - 2); above = 1'b0;
    wait_cyc(c + BF - 1); above = 1'b1;
    wait_cyc(r + BF + 1);

    // R10 external reset from field
    @(negedge clk); c = cyc;
    push(c + 1,      0, 0, 0, "R10 external reset, no pulse");
    push(c + BF,     0, 0, 0, "R10 count restarted");
    push(c + 1 + BF, 1, 0, 1, "R10 requalified");
    pulse_ext();
    wait_cyc(c + BF + 2);

    // R6 tick gating
    @(negedge clk); c = cyc;
    push(c + 1,       0, 0, 0, "R10 external reset");
    push(c + BF + 30, 0, 0, 0, "R6 no advance without tick");
    push(c + BF + 31, 1, 0, 1, "R6 final tick completes");
    pulse_ext();
    wait_cyc(c + BF); tick = 1'b0;
    wait_cyc(c + BF + 30); tick = 1'b1;
    wait_cyc(c + BF + 32);

    // R8 / R9 disable in field, ignored bytes
    @(negedge clk); c = cyc;
    push(c + 1,               1, 0, 0, "R9 one cycle latency");
    push(c + 2,               0, 1, 0, "R9/R5 forced fallback");
    push(c + 1 + RST,         0, 1, 0, "R5 forced pulse width");
    push(c + 2 + RST,         0, 0, 0, "R5 forced pulse ended");
    push(c + 2 + RST + 3*BF,  0, 0, 0, "R8/R9 stays battery, bytes ignored");
    pulse_cmd(8'hC7, 1'b1);
    wait_cyc(c + RST + 5);
    pulse_cmd(8'h8F, 1'b1);
    pulse_cmd(8'hCE, 1'b1);
    pulse_cmd(8'hCF, 1'b0);
    wait_cyc(c + 3 + RST + 3*BF);

    // R10 external reset keeps the disabled flag
    @(negedge clk); c = cyc;
    push(c + 1 + 2*BF, 0, 0, 0, "R10 auto flag kept");
    pulse_ext();
    wait_cyc(c + 2 + 2*BF);

    // R8 enable command
    @(negedge clk); c = cyc;
    push(c + BF,     0, 0, 0, "R8 counting after enable");
    push(c + BF + 1, 1, 0, 1, "R8 enable resumes switching");
    pulse_cmd(8'hDF, 1'b1);
    wait_cyc(c + BF + 2);

    // R1 power-on reset re-enables automatic mode
    @(negedge clk); c = cyc;
    push(c + 1, 1, 0, 0, "R9 latency");
    push(c + 2, 0, 1, 0, "R9 forced fallback");
    pulse_cmd(8'hC7, 1'b1);
    wait_cyc(c + RST + 4);
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); p = cyc;
    push(p + 1,  0, 0, 0, "R1 state after power-on reset");
    push(p + BF, 1, 0, 1, "R1 auto enabled after power-on reset");
    por_n = 1'b1;
    wait_cyc(p + BF + 2);

    while (sb.size() > 0) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule